// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan position, sync pulses, blanking and display-enable for a raster display from a pixel clock. A three-bit pixel counter walks each 8-pixel character, a character counter walks the line and a line counter walks the frame. All horizontal settings are in characters and all vertical settings are in lines. Each setting is held in a register in a biased form that the decoder undoes. The end-of-sync and end-of-blank settings are compared against only a few low bits of the counters.

Software writes the settings one byte at a time into a shadow set. The whole shadow set becomes the working set at the frame boundary, so a frame never runs with a mix of old and new settings. Each of horizontal sync, horizontal blank and vertical sync comes from a two-state machine. Its states are SPAN_OFF and SPAN_ON. The machine moves only on a step, which is a character boundary for the horizontal spans and a line boundary for vertical sync. On a step it takes SPAN_OFF to SPAN_ON when the start position matches. It takes SPAN_ON to SPAN_OFF when the end match hits and the start match does not. In every other case it holds its state. The block also outputs a per-line memory pitch that the fetch logic uses.

Top module: `crtc_timing`

## Requirements
- R1: While reset is high and after it falls, x and y are 0 and the working and shadow sets hold values derived from the size parameters. With the default parameters these give an 800-clock line, a 640-pixel active width, a 96-clock sync starting at pixel 656, a 525-line frame, active-low syncs and a pitch of 80. At reset both sync outputs sit at their idle level.
- R2: The horizontal total is a 9-bit field: bits 7:0 at address 0 and bit 0 of address 1. It holds the character total minus 5, so a line lasts (field+5)×8 clocks. x is the pixel position in the line, and x[2:0] is the pixel within the character.
- R3: de is high when the character is at most the field at address 2 (display width − 1) and the line is at most the 12-bit field at addresses 8 (bits 7:0) and 9 (bits 3:0) (display height − 1).
- R4: Horizontal sync turns on in the character equal to address 3. It turns off in the first later character whose low 5 bits equal address 4 bits 4:0.
- R5: blank turns on in the character equal to display width (address 2 + 1). It turns off in the first later character whose low 6 bits equal address 5 bits 5:0 (total − 1). blank is also high on every line past the display height.
- R6: The vertical total is a 12-bit field: address 6 bits 7:0 and address 7 bits 3:0. It holds the line total minus 2. y advances at each line end and returns to 0 after line field+1.
- R7: Vertical sync turns on at line (field+1), where the 12-bit field is at address 10 (bits 7:0) and address 11 (bits 3:0). It turns off at the first later line whose low 4 bits equal (address 12 bits 3:0) + 1.
- R8: Address 15 bit 6 set makes hsync active-low, and bit 7 set makes vsync active-low. When a bit is clear that sync is active-high.
- R9: The pitch output is the 12-bit field at address 13 (bits 7:0) and address 14 (bits 3:0).
- R10: Writes go to the shadow set. The working set, which drives every output, copies the shadow set only on the clock edge that ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per register |
| vsync | output | 1 | Vertical sync, polarity per register |
| de | output | 1 | Display enable |
| blank | output | 1 | Blanking |
| x | output | 13 | Pixel position in line |
| y | output | 13 | Line number in frame |
| pitch | output | 12 | Memory pitch per line |

## Verification
The main instance is built with a 64-pixel, 11-line default raster. This makes a full frame 704 clocks long, so the bench can measure complete frames for several programmed rasters. It can also measure a write made in the middle of a frame and a reset taken mid-run. Some of those rasters have sync widths past the truncated compare range, which exercises the low-bit end matches. A second instance at the default parameters lets the bench measure one line of the 640-wide mode without running a 420,000-clock frame.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
    localparam int PX_W  = 3;
    localparam int HC_W  = 10;
    localparam int VC_W  = 13;
    localparam int NSPAN = 3;

    localparam int SP_HSYNC  = 0;
    localparam int SP_HBLANK = 1;
    localparam int SP_VSYNC  = 2;

    localparam logic [3:0] A_HTOT_LO  = 4'd0;
    localparam logic [3:0] A_HTOT_HI  = 4'd1;
    localparam logic [3:0] A_HDISP    = 4'd2;
    localparam logic [3:0] A_HS_ON    = 4'd3;
    localparam logic [3:0] A_HS_OFF   = 4'd4;
    localparam logic [3:0] A_HB_OFF   = 4'd5;
    localparam logic [3:0] A_VTOT_LO  = 4'd6;
    localparam logic [3:0] A_VTOT_HI  = 4'd7;
    localparam logic [3:0] A_VDISP_LO = 4'd8;
    localparam logic [3:0] A_VDISP_HI = 4'd9;
    localparam logic [3:0] A_VS_ON_LO = 4'd10;
    localparam logic [3:0] A_VS_ON_HI = 4'd11;
    localparam logic [3:0] A_VS_OFF   = 4'd12;
    localparam logic [3:0] A_PITCH_LO = 4'd13;
    localparam logic [3:0] A_PITCH_HI = 4'd14;
    localparam logic [3:0] A_POL      = 4'd15;

    typedef struct packed {
        logic [8:0]  htot;
        logic [7:0]  hdisp;
        logic [7:0]  hs_on;
        logic [4:0]  hs_off;
        logic [5:0]  hb_off;
        logic [11:0] vtot;
        logic [11:0] vdisp;
        logic [11:0] vs_on;
        logic [3:0]  vs_off;
        logic [11:0] pitch;
        logic        hs_low;
        logic        vs_low;
    } crtc_cfg_t;

    typedef enum logic {
        SPAN_OFF = 1'b0,
        SPAN_ON  = 1'b1
    } span_e;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
    import crtc_pkg::*;
#(
    parameter crtc_cfg_t RST_CFG = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    input  logic       frame_wrap,
    output crtc_cfg_t  act,
    output crtc_cfg_t  nxt
);
    crtc_cfg_t shd;

    // shadow set takes writes; working set follows it only at frame end
    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= RST_CFG;
            act <= RST_CFG;
        end else begin
            if (we) begin
                unique case (addr)
                    A_HTOT_LO:  shd.htot[7:0]   <= wdata;
                    A_HTOT_HI:  shd.htot[8]     <= wdata[0];
                    A_HDISP:    shd.hdisp       <= wdata;
                    A_HS_ON:    shd.hs_on       <= wdata;
                    A_HS_OFF:   shd.hs_off      <= wdata[4:0];
                    A_HB_OFF:   shd.hb_off      <= wdata[5:0];
                    A_VTOT_LO:  shd.vtot[7:0]   <= wdata;
                    A_VTOT_HI:  shd.vtot[11:8]  <= wdata[3:0];
                    A_VDISP_LO: shd.vdisp[7:0]  <= wdata;
                    A_VDISP_HI: shd.vdisp[11:8] <= wdata[3:0];
                    A_VS_ON_LO: shd.vs_on[7:0]  <= wdata;
                    A_VS_ON_HI: shd.vs_on[11:8] <= wdata[3:0];
                    A_VS_OFF:   shd.vs_off      <= wdata[3:0];
                    A_PITCH_LO: shd.pitch[7:0]  <= wdata;
                    A_PITCH_HI: shd.pitch[11:8] <= wdata[3:0];
                    A_POL: begin
                        shd.hs_low <= wdata[6];
                        shd.vs_low <= wdata[7];
                    end
                endcase
            end
            if (frame_wrap) begin
                act <= shd;
            end
        end
    end

    // settings that govern the position the counters move to next
    assign nxt = frame_wrap ? shd : act;
endmodule

// File: rtl/crtc_counters.sv
module crtc_counters
    import crtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  crtc_cfg_t       act,
    output logic [PX_W-1:0] px,
    output logic [HC_W-1:0] hc,
    output logic [VC_W-1:0] vc,
    output logic [HC_W-1:0] hc_n,
    output logic [VC_W-1:0] vc_n,
    output logic            char_end,
    output logic            line_end,
    output logic            frame_wrap
);
    logic [HC_W-1:0] h_last;
    logic [VC_W-1:0] v_last;

    always_comb begin
        // undo the register bias: total-5 characters, total-2 lines
        h_last     = HC_W'(act.htot) + HC_W'(4);
        v_last     = VC_W'(act.vtot) + VC_W'(1);
        char_end   = (px == '1);
        line_end   = char_end && (hc == h_last);
        frame_wrap = line_end && (vc == v_last);
        hc_n = hc;
        if (char_end) begin
            hc_n = line_end ? '0 : hc + 1'b1;
        end
        vc_n = vc;
        if (line_end) begin
            vc_n = frame_wrap ? '0 : vc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            px <= '0;
            hc <= '0;
            vc <= '0;
        end else begin
            px <= px + 1'b1;
            hc <= hc_n;
            vc <= vc_n;
        end
    end
endmodule

// File: rtl/crtc_span.sv
module crtc_span
    import crtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic hit_on,
    input  logic hit_off,
    output logic active
);
    span_e st, st_n;

    always_comb begin
        st_n = st;
        if (step) begin
            unique case (st)
                SPAN_OFF: if (hit_on) st_n = SPAN_ON;
                SPAN_ON:  if (!hit_on && hit_off) st_n = SPAN_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SPAN_OFF;
        end else begin
            st <= st_n;
        end
    end

    always_comb begin
        active = (st == SPAN_ON);
    end
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
    import crtc_pkg::*;
#(
    parameter int         H_ACTIVE = 640,
    parameter int         H_FRONT  = 16,
    parameter int         H_SYNC   = 96,
    parameter int         H_BACK   = 48,
    parameter int         V_ACTIVE = 480,
    parameter int         V_FRONT  = 10,
    parameter int         V_SYNC   = 2,
    parameter int         V_BACK   = 33,
    parameter int         BYTES_PP = 1,
    parameter logic [1:0] SYNC_LOW = 2'b11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 de,
    output logic                 blank,
    output logic [HC_W+PX_W-1:0] x,
    output logic [VC_W-1:0]      y,
    output logic [11:0]          pitch
);
    localparam int HD_C    = H_ACTIVE / 8;
    localparam int HS_C    = (H_ACTIVE + H_FRONT) / 8;
    localparam int HE_C    = (H_ACTIVE + H_FRONT + H_SYNC) / 8;
    localparam int HT_C    = (H_ACTIVE + H_FRONT + H_SYNC + H_BACK) / 8;
    localparam int VS_L    = V_ACTIVE + V_FRONT;
    localparam int VE_L    = VS_L + V_SYNC;
    localparam int VT_L    = VE_L + V_BACK;
    localparam int PITCH_D = H_ACTIVE * BYTES_PP / 8;

    localparam crtc_cfg_t RST_CFG = '{
        htot:   9'(HT_C - 5),
        hdisp:  8'(HD_C - 1),
        hs_on:  8'(HS_C),
        hs_off: 5'(HE_C % 32),
        hb_off: 6'((HT_C - 1) % 64),
        vtot:   12'(VT_L - 2),
        vdisp:  12'(V_ACTIVE - 1),
        vs_on:  12'(VS_L - 1),
        vs_off: 4'((VE_L - 1) % 16),
        pitch:  12'(PITCH_D),
        hs_low: SYNC_LOW[0],
        vs_low: SYNC_LOW[1]
    };

    crtc_cfg_t       act, nxt;
    logic [PX_W-1:0] px;
    logic [HC_W-1:0] hc, hc_n;
    logic [VC_W-1:0] vc, vc_n;
    logic            char_end, line_end, frame_wrap;
    logic [NSPAN-1:0] sp_step, sp_on, sp_off, sp_act;

    crtc_regs #(.RST_CFG(RST_CFG)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .frame_wrap (frame_wrap),
        .act        (act),
        .nxt        (nxt)
    );

    crtc_counters u_cnt (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .px         (px),
        .hc         (hc),
        .vc         (vc),
        .hc_n       (hc_n),
        .vc_n       (vc_n),
        .char_end   (char_end),
        .line_end   (line_end),
        .frame_wrap (frame_wrap)
    );

    // span matches look at the position being entered, with the settings
    // that will be in force there
    always_comb begin
        sp_step[SP_HSYNC]  = char_end;
        sp_on[SP_HSYNC]    = (hc_n == HC_W'(nxt.hs_on));
        sp_off[SP_HSYNC]   = (hc_n[4:0] == nxt.hs_off);

        sp_step[SP_HBLANK] = char_end;
        sp_on[SP_HBLANK]   = (hc_n == HC_W'(nxt.hdisp) + HC_W'(1));
        sp_off[SP_HBLANK]  = (hc_n[5:0] == nxt.hb_off);

        sp_step[SP_VSYNC]  = line_end;
        sp_on[SP_VSYNC]    = (vc_n == VC_W'(nxt.vs_on) + VC_W'(1));
        sp_off[SP_VSYNC]   = (vc_n[3:0] == nxt.vs_off + 4'd1);
    end

    for (genvar g = 0; g < NSPAN; g++) begin : g_span
        crtc_span u_span (
            .clk     (clk),
            .rst     (rst),
            .step    (sp_step[g]),
            .hit_on  (sp_on[g]),
            .hit_off (sp_off[g]),
            .active  (sp_act[g])
        );
    end

    always_comb begin
        x     = {hc, px};
        y     = vc;
        de    = (hc <= HC_W'(act.hdisp)) && (vc <= VC_W'(act.vdisp));
        blank = sp_act[SP_HBLANK] || (vc > VC_W'(act.vdisp));
        hsync = sp_act[SP_HSYNC] ^ act.hs_low;
        vsync = sp_act[SP_VSYNC] ^ act.vs_low;
        pitch = act.pitch;
    end
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
    import crtc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [HC_W+PX_W-1:0] x,
    input logic [VC_W-1:0]      y,
    input logic                 de,
    input logic                 blank,
    input logic                 hsync,
    input logic                 vsync,
    input logic [11:0]          pitch
);
    p_x_step_r2: assert property (@(posedge clk) disable iff (rst)
        (x[PX_W-1:0] != '1) |=> (x == $past(x) + 1'b1));

    p_y_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (x[PX_W-1:0] != '1) |=> $stable(y));

    p_de_unblanked_r5: assert property (@(posedge clk) disable iff (rst)
        de |-> !blank);

    p_hsync_char_r4: assert property (@(posedge clk) disable iff (rst)
        (x[PX_W-1:0] != '0) |-> $stable(hsync));

    p_vsync_line_r7: assert property (@(posedge clk) disable iff (rst)
        (x != '0) |-> $stable(vsync));

    p_pitch_frame_r10: assert property (@(posedge clk) disable iff (rst)
        !(x == '0 && y == '0) |-> $stable(pitch));
endmodule

bind crtc_timing crtc_timing_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .x     (x),
    .y     (y),
    .de    (de),
    .blank (blank),
    .hsync (hsync),
    .vsync (vsync),
    .pitch (pitch)
);

// File: tb/crtc_timing_test.sv
module crtc_timing_test;
    import crtc_pkg::*;

    typedef struct packed {
        int ht; int hd; int hs; int he;
        int vt; int vd; int vs; int ve;
        int pol; int pitch;
    } row_t;

    // rasters in characters / lines; row 0 equals the bench defaults
    localparam row_t ROWS [5] = '{
        '{8,  4,  5,  7,  11, 6,  7,  9,  3, 8},
        '{12, 8,  9,  11, 14, 10, 11, 12, 0, 300},
        '{48, 30, 40, 74, 20, 12, 14, 17, 1, 4095},
        '{20, 10, 12, 16, 30, 6,  8,  25, 2, 1},
        '{6,  1,  2,  4,  4,  1,  2,  3,  3, 1445}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [7:0]  wdata = 8'd0;
    logic        hsync, vsync, de, blank;
    logic [12:0] x, y;
    logic [11:0] pitch;
    logic        d_hsync, d_vsync, d_de, d_blank;
    logic [12:0] d_x, d_y;
    logic [11:0] d_pitch;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    crtc_timing #(
        .H_ACTIVE(32), .H_FRONT(8), .H_SYNC(16), .H_BACK(8),
        .V_ACTIVE(6), .V_FRONT(1), .V_SYNC(2), .V_BACK(2),
        .BYTES_PP(2), .SYNC_LOW(2'b11)
    ) uut (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
        .hsync(hsync), .vsync(vsync), .de(de), .blank(blank),
        .x(x), .y(y), .pitch(pitch)
    );

    crtc_timing uut_dflt (
        .clk(clk), .rst(rst), .cfg_we(1'b0), .cfg_addr(4'd0), .cfg_wdata(8'd0),
        .hsync(d_hsync), .vsync(d_vsync), .de(d_de), .blank(d_blank),
        .x(d_x), .y(d_y), .pitch(d_pitch)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = 8'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic program_row(input row_t r);
        wr(A_HTOT_LO,  (r.ht - 5) & 255);
        wr(A_HTOT_HI,  ((r.ht - 5) >> 8) & 1);
        wr(A_HDISP,    r.hd - 1);
        wr(A_HS_ON,    r.hs);
        wr(A_HS_OFF,   r.he & 31);
        wr(A_HB_OFF,   (r.ht - 1) & 63);
        wr(A_VTOT_LO,  (r.vt - 2) & 255);
        wr(A_VTOT_HI,  (r.vt - 2) >> 8);
        wr(A_VDISP_LO, (r.vd - 1) & 255);
        wr(A_VDISP_HI, (r.vd - 1) >> 8);
        wr(A_VS_ON_LO, (r.vs - 1) & 255);
        wr(A_VS_ON_HI, (r.vs - 1) >> 8);
        wr(A_VS_OFF,   (r.ve - 1) & 15);
        wr(A_PITCH_LO, r.pitch & 255);
        wr(A_PITCH_HI, r.pitch >> 8);
        wr(A_POL,      r.pol << 6);
    endtask

    // waits for the next frame start, then measures that whole frame
    task automatic measure_frame(input logic hs_act, input logic vs_act,
                                 output int cyc, output int de_n, output int hs_n,
                                 output int vs_n, output int bl_n, output int first_hs,
                                 output int hs0, output int vs0);
        cyc = 0; de_n = 0; hs_n = 0; vs_n = 0; bl_n = 0; first_hs = -1;
        @(negedge clk);
        while (!(x == 0 && y == 0)) @(negedge clk);
        hs0 = int'(hsync);
        vs0 = int'(vsync);
        do begin
            cyc++;
            if (de) de_n++;
            if (blank) bl_n++;
            if (vsync == vs_act) vs_n++;
            if (hsync == hs_act) begin
                hs_n++;
                if (first_hs < 0 && y == 0) first_hs = int'(x);
            end
            @(negedge clk);
        end while (!(x == 0 && y == 0));
    endtask

    task automatic check_row(input string tag, input row_t r);
        int cyc, de_n, hs_n, vs_n, bl_n, first_hs, hs0, vs0;
        int wh, wv;
        logic hs_act, vs_act;
        hs_act = (r.pol & 1) ? 1'b0 : 1'b1;
        vs_act = (r.pol & 2) ? 1'b0 : 1'b1;
        measure_frame(hs_act, vs_act, cyc, de_n, hs_n, vs_n, bl_n, first_hs, hs0, vs0);
        wh = (r.he - r.hs) % 32;
        if (wh == 0) wh = 32;
        wv = (r.ve - r.vs) % 16;
        if (wv == 0) wv = 16;
        $display("%s raster %0dx%0d chars/lines", tag, r.ht, r.vt);
        chk("R2 R6 frame length", cyc, r.ht * 8 * r.vt);
        chk("R3 display-enable clocks", de_n, r.hd * 8 * r.vd);
        chk("R4 hsync active clocks", hs_n, wh * 8 * r.vt);
        chk("R4 hsync start pixel", first_hs, r.hs * 8);
        chk("R7 vsync active clocks", vs_n, wv * r.ht * 8);
        chk("R5 blank clocks", bl_n, r.vd * (r.ht - 1 - r.hd) * 8 + (r.vt - r.vd) * r.ht * 8);
        chk("R8 hsync idle level", hs0, int'(!hs_act));
        chk("R8 vsync idle level", vs0, int'(!vs_act));
        chk("R9 pitch", int'(pitch), r.pitch);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 150000 cycles expected completion earlier");
        summary();
    end

    initial begin
        int cyc, de_n, lo_n, first_lo;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 x at reset", int'(x), 0);
        chk("R1 y at reset", int'(y), 0);
        chk("R1 hsync idle at reset", int'(hsync), 1);
        chk("R1 vsync idle at reset", int'(vsync), 1);
        chk("R1 de at reset", int'(de), 1);
        chk("R1 blank at reset", int'(blank), 0);
        chk("R1 pitch at reset", int'(pitch), 8);
        chk("R1 default pitch 640 mode", int'(d_pitch), 80);
        chk("R1 default hsync idle", int'(d_hsync), 1);
        rst = 1'b0;

        // R1: one line of the default 640-wide mode
        @(negedge clk);
        while (d_x != 0) @(negedge clk);
        cyc = 0; de_n = 0; lo_n = 0; first_lo = -1;
        do begin
            cyc++;
            if (d_de) de_n++;
            if (!d_hsync) begin
                lo_n++;
                if (first_lo < 0) first_lo = int'(d_x);
            end
            @(negedge clk);
        end while (d_x != 0);
        chk("R1 default line length", cyc, 800);
        chk("R1 default active width", de_n, 640);
        chk("R1 default hsync width", lo_n, 96);
        chk("R1 default hsync start", first_lo, 656);

        // R1: parameter defaults of the bench instance
        check_row("R1 defaults", ROWS[0]);

        // stimulus table
        for (int i = 0; i < 5; i++) begin
            program_row(ROWS[i]);
            check_row("table", ROWS[i]);
        end

        // R10: a write mid-frame leaves the running frame alone
        @(negedge clk);
        while (!(x == 0 && y == 1)) @(negedge clk);
        wr(A_HTOT_LO, 5);
        while (!(x == 0 && y == 2)) @(negedge clk);
        cyc = 0;
        do begin cyc++; @(negedge clk); end while (x != 0);
        chk("R10 running frame keeps old total", cyc, 48);
        while (!(x == 0 && y == 0)) @(negedge clk);
        cyc = 0;
        do begin cyc++; @(negedge clk); end while (x != 0);
        chk("R10 R2 next frame uses new total", cyc, 80);

        // R1: reset in mid-run restores defaults
        while (!(x == 0 && y == 1)) @(negedge clk);
        repeat (13) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 x after mid-run reset", int'(x), 0);
        chk("R1 y after mid-run reset", int'(y), 0);
        chk("R1 pitch after mid-run reset", int'(pitch), 8);
        rst = 1'b0;
        check_row("R1 after reset", ROWS[0]);

        summary();
    end
endmodule